// File: doc/BRIEF.md
# Command-Line Completion Waiter

This block sits in the host command path of an SD/MMC-style controller. After the command engine has sent a command, it can wait for the device to signal that a long-running operation has finished. It does this by watching the CMD line for a single start bit instead of a full response frame. Whether it waits depends on three control bits: a mode bit for the attached-storage command set, an enable-completion bit and a suppress-interrupt bit. If they do not allow the wait, the block stays idle.

When the start bit arrives, the block raises a one-cycle completion pulse. It then holds off the next command for a fixed quiet window of card-clock bit cycles. For the first part of the window the CMD pin is released. For the rest of the window the host drives the pin high in push-pull fashion. Once the window has expired, the ready output tells the command engine that it may issue its next command, normally a fast I/O read of the device status register.

All sampling and counting happen on rising clock edges on which the clock enable is high. A synchronous abort ends a pending wait without any completion.

Top module: `cmd_cmpl_waiter`

## Requirements
- R1: While mode_en is 0, a cmd_sent strobe never starts a wait: ready stays 1, cmd_oe stays 0 and cmpl_pulse stays 0.
- R2: With mode_en at 1, an enabled edge that sees cmd_sent starts a wait only when cmpl_en is 1 and no_irq is 0. Otherwise the block stays idle with ready at 1.
- R3: During a wait, an enabled edge that samples cmd_in at 0 (the start bit) ends the wait. A sample of 1, or an edge with clk_en at 0, keeps the block waiting.
- R4: The edge that detects the start bit makes cmpl_pulse 1 for exactly one clock cycle. cmpl_pulse is 0 at all other times.
- R5: After the start bit, a lockout lasts 7 enabled cycles. During the first 2 of them, cmd_oe and cmd_out are 0. During the last 5, cmd_oe is 1 and cmd_out is 1. Outside the lockout, cmd_oe and cmd_out are 0.
- R6: ready is 0 from the edge that starts a wait until the lockout has expired, and 1 otherwise.
- R7: An enabled edge with abort at 1 during a wait returns the block to idle (ready 1, cmd_oe 0) without a completion pulse.
- R8: Edges with clk_en at 0 change neither the state nor the lockout count.
- R9: Asynchronous reset (rst_n at 0) gives ready 1, cmd_oe 0, cmd_out 0 and cmpl_pulse 0.
- R10: cmd_sent during a wait or a lockout is ignored, and abort during a lockout or in idle is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Card clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Bit-cycle enable; all sampling and counting are qualified by it |
| mode_en | input | 1 | Completion-handling mode enable |
| cmpl_en | input | 1 | Request to wait for the completion signal |
| no_irq | input | 1 | Suppress completion waiting when 1 |
| cmd_sent | input | 1 | Command engine has just finished sending a command |
| abort | input | 1 | Synchronous abort of a pending wait |
| cmd_in | input | 1 | Sampled CMD line level |
| cmd_oe | output | 1 | CMD push-pull driver enable |
| cmd_out | output | 1 | CMD driven level |
| cmpl_pulse | output | 1 | One-cycle completion indication |
| ready | output | 1 | Next command may be issued |

## Verification
The assertions assume that every input is 0 or 1 at each rising edge and changes only away from that edge. They also assume that cmd_sent and abort are acted on only on enabled edges, so a strobe on a disabled edge is lost by design. The stimulus changes every input on the falling edge and draws all values from a seeded generator. It biases cmd_in toward 1 so that waits last several cycles. It keeps abort rare so that lockouts run to completion, and the directed cases place a stalled clk_en and overlapping strobes inside the windows that matter.

// File: rtl/cmpl_pkg.sv
package cmpl_pkg;

  // Phases of the completion waiter.
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_QUIET = 2'd2
  } cw_state_e;

endpackage

// File: rtl/cw_fsm.sv
module cw_fsm
  import cmpl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clk_en,
  input  logic      mode_en,
  input  logic      cmpl_en,
  input  logic      no_irq,
  input  logic      cmd_sent,
  input  logic      abort,
  input  logic      cmd_in,
  input  logic      lock_done,
  output cw_state_e state_o,
  output logic      lock_start,
  output logic      cmpl_pulse
);

  cw_state_e st_q, st_d;
  logic      pulse_q;
  logic      arm_ok;

  // Wait is allowed only in the completion mode with the enable set and the
  // suppress bit clear.
  assign arm_ok = mode_en & cmpl_en & ~no_irq;

  always_comb begin
    st_d       = st_q;
    lock_start = 1'b0;
    if (clk_en) begin
      unique case (st_q)
        ST_IDLE: begin
          if (cmd_sent && arm_ok) begin
            st_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (abort) begin
            st_d = ST_IDLE;
          end else if (!cmd_in) begin
            st_d       = ST_QUIET;
            lock_start = 1'b1;
          end
        end
        ST_QUIET: begin
          if (lock_done) begin
            st_d = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      pulse_q <= lock_start;
    end
  end

  assign state_o    = st_q;
  assign cmpl_pulse = pulse_q;

  AST_ARM_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && clk_en && cmd_sent && !(mode_en && cmpl_en && !no_irq))
      |=> (st_q == ST_IDLE)); // R2

  AST_ARM_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && clk_en && cmd_sent && mode_en && cmpl_en && !no_irq)
      |=> (st_q == ST_WAIT)); // R2

  AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && !abort && cmd_in) |=> (st_q == ST_WAIT)); // R3

  AST_ABORT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WAIT && clk_en && abort) |=> (st_q == ST_IDLE && !pulse_q)); // R7

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en) |=> $stable(st_q)); // R8

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |=> !pulse_q); // R4

  AST_PULSE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q |-> (st_q == ST_QUIET)); // R4

endmodule

// File: rtl/cw_lockout.sv
module cw_lockout #(
  parameter int QUIET_CYCLES = 7,
  parameter int DRIVE_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic in_quiet,
  input  logic lock_start,
  output logic lock_done,
  output logic drive_on
);

  localparam int CNT_W       = (QUIET_CYCLES > 1) ? $clog2(QUIET_CYCLES) : 1;
  localparam int LAST_IDX    = QUIET_CYCLES - 1;
  localparam int FLOAT_COUNT = QUIET_CYCLES - DRIVE_CYCLES;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (lock_start) begin
      cnt_d = '0;
    end else if (in_quiet && clk_en && !lock_done) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign lock_done = (cnt_q == CNT_W'(LAST_IDX));
  assign drive_on  = in_quiet && (cnt_q >= CNT_W'(FLOAT_COUNT));

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_quiet |-> (cnt_q <= CNT_W'(LAST_IDX))); // R5

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_quiet && clk_en && !lock_done && !lock_start)
      |=> (cnt_q == $past(cnt_q) + CNT_W'(1))); // R5

  AST_CNT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en && !lock_start) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/cw_drive.sv
module cw_drive
  import cmpl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  cw_state_e state_i,
  input  logic      drive_on,
  output logic      cmd_oe,
  output logic      cmd_out,
  output logic      ready
);

  assign cmd_oe  = drive_on;
  assign cmd_out = drive_on;
  assign ready   = (state_i == ST_IDLE);

  AST_DRIVE_IN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> (state_i == ST_QUIET && !ready)); // R5

  AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_oe |-> cmd_out); // R5

endmodule

// File: rtl/cmd_cmpl_waiter.sv
module cmd_cmpl_waiter
  import cmpl_pkg::*;
#(
  parameter int QUIET_CYCLES = 7,
  parameter int DRIVE_CYCLES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_en,
  input  logic mode_en,
  input  logic cmpl_en,
  input  logic no_irq,
  input  logic cmd_sent,
  input  logic abort,
  input  logic cmd_in,
  output logic cmd_oe,
  output logic cmd_out,
  output logic cmpl_pulse,
  output logic ready
);

  cw_state_e state;
  logic      lock_start;
  logic      lock_done;
  logic      drive_on;
  logic      in_quiet;

  assign in_quiet = (state == ST_QUIET);

  cw_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .mode_en    (mode_en),
    .cmpl_en    (cmpl_en),
    .no_irq     (no_irq),
    .cmd_sent   (cmd_sent),
    .abort      (abort),
    .cmd_in     (cmd_in),
    .lock_done  (lock_done),
    .state_o    (state),
    .lock_start (lock_start),
    .cmpl_pulse (cmpl_pulse)
  );

  cw_lockout #(
    .QUIET_CYCLES (QUIET_CYCLES),
    .DRIVE_CYCLES (DRIVE_CYCLES)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .clk_en     (clk_en),
    .in_quiet   (in_quiet),
    .lock_start (lock_start),
    .lock_done  (lock_done),
    .drive_on   (drive_on)
  );

  cw_drive u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .drive_on (drive_on),
    .cmd_oe   (cmd_oe),
    .cmd_out  (cmd_out),
    .ready    (ready)
  );

  AST_BUSY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_pulse |-> (!ready && !cmd_oe)); // R6

  AST_NO_WAIT_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !mode_en) |=> ready); // R1

  AST_SENT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !cmpl_pulse && cmd_oe && clk_en && cmd_sent && !lock_done) |=> !ready); // R10

endmodule

// File: tb/sim_cmd_cmpl_waiter.sv
module sim_cmd_cmpl_waiter;

  logic clk = 1'b0;
  logic rst_n, clk_en, mode_en, cmpl_en, no_irq, cmd_sent, abort, cmd_in;
  logic cmd_oe, cmd_out, cmpl_pulse, ready;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  cmd_cmpl_waiter u0 (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .mode_en(mode_en),
    .cmpl_en(cmpl_en), .no_irq(no_irq), .cmd_sent(cmd_sent), .abort(abort),
    .cmd_in(cmd_in), .cmd_oe(cmd_oe), .cmd_out(cmd_out),
    .cmpl_pulse(cmpl_pulse), .ready(ready)
  );

  // Reference model built from the requirements: 0 idle, 1 wait, 2 lockout.
  int m_ph  = 0;
  int m_cnt = 0;
  bit m_pls = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph <= 0; m_cnt <= 0; m_pls <= 0;
    end else begin
      m_pls <= 0;
      if (clk_en) begin
        case (m_ph)
          0: if (cmd_sent && mode_en && cmpl_en && !no_irq) m_ph <= 1;
          1: if (abort) m_ph <= 0;
             else if (!cmd_in) begin m_ph <= 2; m_cnt <= 0; m_pls <= 1; end
          default: if (m_cnt == 6) m_ph <= 0; else m_cnt <= m_cnt + 1;
        endcase
      end
    end
  end

  function automatic bit exp_oe();
    return (m_ph == 2) && (m_cnt >= 2);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic check_all(input string ctx);
    chk({ctx, "/R6"}, ready,      1'(m_ph == 0), "ready");
    chk({ctx, "/R5"}, cmd_oe,     exp_oe(),      "cmd_oe");
    chk({ctx, "/R5"}, cmd_out,    exp_oe(),      "cmd_out");
    chk({ctx, "/R4"}, cmpl_pulse, m_pls,         "cmpl_pulse");
  endtask

  task automatic tick(input string ctx);
    @(negedge clk);
    check_all(ctx);
  endtask

  task automatic quiet_in();
    clk_en = 1; mode_en = 1; cmpl_en = 1; no_irq = 0;
    cmd_sent = 0; abort = 0; cmd_in = 1;
  endtask

  initial begin : watchdog
    #1500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; quiet_in();
    #23;
    check_all("R9");
    @(negedge clk); rst_n = 1;
    tick("R9");

    // R1: mode off
    mode_en = 0; cmd_sent = 1; tick("R1");
    cmd_sent = 0; cmd_in = 0; tick("R1"); tick("R1");

    // R2: each blocked combination, then the allowed one
    quiet_in(); no_irq = 1; cmd_sent = 1; tick("R2"); cmd_sent = 0; tick("R2");
    quiet_in(); cmpl_en = 0; cmd_sent = 1; tick("R2"); cmd_sent = 0; tick("R2");
    quiet_in(); cmd_sent = 1; tick("R2"); cmd_sent = 0;

    // R3: stay waiting on 1, R8 stall, R10 strobes ignored
    tick("R3"); tick("R3");
    cmd_in = 0; clk_en = 0; tick("R8"); tick("R8");
    clk_en = 1; cmd_sent = 1; tick("R3");
    cmd_in = 1; cmd_sent = 1; abort = 1; tick("R10");
    abort = 0; clk_en = 0; tick("R8"); clk_en = 1;
    for (int i = 0; i < 7; i++) tick("R5");
    cmd_sent = 0; tick("R6");

    // R7: abort in wait
    cmd_sent = 1; tick("R7"); cmd_sent = 0; tick("R7");
    abort = 1; cmd_in = 0; tick("R7");
    abort = 0; cmd_in = 1; tick("R7"); tick("R10");

    // Mid-lockout reset (R9)
    cmd_sent = 1; tick("R9"); cmd_sent = 0; cmd_in = 0; tick("R9");
    cmd_in = 1; tick("R9"); tick("R9"); tick("R9");
    #2 rst_n = 0; #1 check_all("R9");
    @(negedge clk); rst_n = 1; tick("R9");

    // Random phase with a fixed seed
    void'($urandom(32'h5eed_c0de));
    for (int i = 0; i < 4000; i++) begin
      clk_en   = ($urandom % 4) != 0;
      mode_en  = ($urandom % 8) != 0;
      cmpl_en  = ($urandom % 6) != 0;
      no_irq   = ($urandom % 6) == 0;
      cmd_sent = ($urandom % 5) == 0;
      abort    = ($urandom % 40) == 0;
      cmd_in   = ($urandom % 6) != 0;
      tick("RND");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule